// File: doc/BRIEF.md
# Three-Stage Interlocked Integer Pipeline

This block is a small in-order integer core in which three instructions overlap: one is being fetched, one is being executed and one is writing its result back. Its instruction set is minimal: load a signed constant, add two registers, add a signed constant to a register, branch when a register is nonzero, and return from interrupt. It reads instructions through a synchronous memory port that answers one cycle after the address is presented. It holds eight general registers, and register 0 is tied to zero. Each instruction that leaves the writeback stage appears on a trace port, which a checker uses to follow the architectural state.

There is no forwarding path. The register file is written at the end of the writeback cycle, so an instruction that needs that result holds in execute for one cycle, and a bubble moves ahead of it. Branch outcomes and interrupt acceptance are settled in the writeback stage. A redirect therefore discards the two younger instructions and fetches again from the new address.

Top module: `pipe3_core`

## Requirements
- R1: While reset is asserted and afterwards until the first instruction reaches writeback, `ret_valid` and `irq_ack` stay low. The first fetch address after reset is 0. The instruction at address 0 retires in the third cycle after the first rising edge with reset released.
- R2: The address presented on `imem_addr` in cycle t returns its word on `imem_rdata` in cycle t+1. Instructions with no dependency between them retire on consecutive clocks at consecutive addresses.
- R3: Instruction word fields: opcode in bits 15:12, destination in 11:9, first source in 8:6, signed 6-bit immediate in 5:0 (its low three bits name the second source of an add). Opcodes: 1 load sign-extended immediate; 2 add first and second source; 3 add first source and sign-extended immediate; 4 branch if nonzero; 5 return from interrupt. Opcode 0 and every opcode from 6 to 15 retire without effect. Sums wrap modulo 2^DATA_W.
- R4: When the instruction in execute reads a nonzero register that the instruction in writeback is writing, exactly one bubble is inserted. The dependent instruction then uses the new value and retires two cycles after its producer.
- R5: Reading a register written two or more instructions earlier, or reading register 0, causes no bubble.
- R6: Register 0 always reads as zero. An instruction whose destination is 0 retires with `ret_wen` low.
- R7: Opcode 4 is taken when its first source is nonzero, with target = its own address + sign-extended immediate. A taken branch discards the two younger instructions, and the target retires three cycles after the branch. A branch that is not taken discards nothing.
- R8: When `irq` is high, interrupts are unmasked, and the writeback stage holds an instruction that does not redirect, `irq_ack` is high in that cycle. That instruction retires, the two younger ones are discarded, the return address (its address + 1) is saved, interrupts become masked, and fetch continues at `IRQ_VEC`.
- R9: While interrupts are masked, `irq` is ignored. Opcode 5 redirects to the saved return address, with the same two-slot penalty as a taken branch, and unmasks interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PC_W | Instruction fetch address for the next cycle |
| imem_rdata | input | 16 | Instruction word for the address presented one cycle earlier |
| irq | input | 1 | Level-sensitive interrupt request |
| irq_ack | output | 1 | High in the cycle an interrupt is accepted |
| ret_valid | output | 1 | An instruction retires this cycle |
| ret_pc | output | PC_W | Address of the retiring instruction |
| ret_wen | output | 1 | The retiring instruction writes a register |
| ret_rd | output | 3 | Destination register of the retiring instruction |
| ret_data | output | DATA_W | Value written by the retiring instruction |

## Verification
A missed interlock shows up at the ports at once. The dependent instruction retires one cycle early and carries a sum built from the stale register value. A squash that leaks lets a wrong-path instruction appear on the trace at the exact slot where a bubble should be. A wrong saved return address or a stuck interrupt mask is caught when the handler returns: the next retired address, or the next acknowledgement, differs from what is expected. The bench recomputes every retirement slot and value from the instruction set rules and compares them on every clock, so any divergence is reported in the cycle it first reaches the trace.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
   localparam int INSN_W = 16;
   localparam int RIDX_W = 3;
   localparam int IMM_W  = 6;

   localparam logic [3:0] OP_LI   = 4'd1;
   localparam logic [3:0] OP_ADD  = 4'd2;
   localparam logic [3:0] OP_ADDI = 4'd3;
   localparam logic [3:0] OP_BNZ  = 4'd4;
   localparam logic [3:0] OP_IRET = 4'd5;

   typedef struct packed {
      logic [3:0]        op;
      logic [RIDX_W-1:0] rd;
      logic [RIDX_W-1:0] rs;
      logic [IMM_W-1:0]  imm;
   } insn_t;
endpackage

// File: rtl/pipe3_regfile.sv
module pipe3_regfile
   import pipe3_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit RESET_REGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RIDX_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [RIDX_W-1:0] ra,
   input  logic [RIDX_W-1:0] rb,
   output logic [DATA_W-1:0] rda,
   output logic [DATA_W-1:0] rdb
);
   localparam int NREG = 1 << RIDX_W;

   logic [DATA_W-1:0] bank [NREG];

   generate
      if (RESET_REGS) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) bank[i] <= '0;
            end else begin
               bank[0] <= '0;
               if (we && wa != '0) bank[wa] <= wd;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            bank[0] <= '0;
            if (we && wa != '0) bank[wa] <= wd;
         end
      end
   endgenerate

   assign rda = (ra == '0) ? '0 : bank[ra];
   assign rdb = (rb == '0) ? '0 : bank[rb];
endmodule

// File: rtl/pipe3_exec.sv
module pipe3_exec
   import pipe3_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PC_W   = 8
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [PC_W-1:0]   pc,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [PC_W-1:0]   epc,
   output logic [RIDX_W-1:0] src_a,
   output logic [RIDX_W-1:0] src_b,
   output logic              use_a,
   output logic              use_b,
   output logic [DATA_W-1:0] result,
   output logic              wen,
   output logic [RIDX_W-1:0] dst,
   output logic              redir,
   output logic              is_ret,
   output logic [PC_W-1:0]   target
);
   insn_t             d;
   logic [DATA_W-1:0] imm_d;
   logic [PC_W-1:0]   imm_p;

   assign d     = insn_t'(insn);
   assign imm_d = {{(DATA_W-IMM_W){d.imm[IMM_W-1]}}, d.imm};
   assign imm_p = {{(PC_W-IMM_W){d.imm[IMM_W-1]}}, d.imm};
   assign src_a = d.rs;
   assign src_b = d.imm[RIDX_W-1:0];
   assign dst   = d.rd;

   always_comb begin
      use_a  = 1'b0;
      use_b  = 1'b0;
      result = '0;
      wen    = 1'b0;
      redir  = 1'b0;
      is_ret = 1'b0;
      target = pc + imm_p;
      unique case (d.op)
         OP_LI:   begin result = imm_d; wen = 1'b1; end
         OP_ADD:  begin use_a = 1'b1; use_b = 1'b1; result = opa + opb; wen = 1'b1; end
         OP_ADDI: begin use_a = 1'b1; result = opa + imm_d; wen = 1'b1; end
         OP_BNZ:  begin use_a = 1'b1; redir = (opa != '0); end
         OP_IRET: begin redir = 1'b1; is_ret = 1'b1; target = epc; end
         default: ;
      endcase
      if (d.rd == '0) wen = 1'b0;
   end
endmodule

// File: rtl/pipe3_hazard.sv
module pipe3_hazard
   import pipe3_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              x_valid,
   input  logic              use_a,
   input  logic              use_b,
   input  logic [RIDX_W-1:0] src_a,
   input  logic [RIDX_W-1:0] src_b,
   input  logic              s_valid,
   input  logic              s_wen,
   input  logic [RIDX_W-1:0] s_dst,
   output logic              raw
);
   logic hit_a, hit_b;

   assign hit_a = use_a && (src_a == s_dst);
   assign hit_b = use_b && (src_b == s_dst);
   assign raw   = x_valid && s_valid && s_wen && (hit_a || hit_b);

   // R5
   raw_needs_real_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raw |-> (s_dst != '0));
endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
   import pipe3_pkg::*;
#(
   parameter int              DATA_W     = 16,
   parameter int              PC_W       = 8,
   parameter logic [PC_W-1:0] IRQ_VEC    = 8'h80,
   parameter bit              RESET_REGS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PC_W-1:0]   imem_addr,
   input  logic [15:0]       imem_rdata,
   input  logic              irq,
   output logic              irq_ack,
   output logic              ret_valid,
   output logic [PC_W-1:0]   ret_pc,
   output logic              ret_wen,
   output logic [2:0]        ret_rd,
   output logic [DATA_W-1:0] ret_data
);
   generate
      if (DATA_W <= IMM_W) begin : g_bad_data_w
         $error("DATA_W must exceed the immediate width");
      end
      if (PC_W <= IMM_W) begin : g_bad_pc_w
         $error("PC_W must exceed the immediate width");
      end
   endgenerate

   // fetch stage
   logic [PC_W-1:0]   f_pc, pc_seq;
   logic              f_valid;
   // execute stage
   logic              x_valid;
   logic [PC_W-1:0]   x_pc;
   logic [INSN_W-1:0] x_insn;
   // writeback stage
   logic              s_valid, s_wen, s_redir, s_ret;
   logic [PC_W-1:0]   s_pc, s_target;
   logic [RIDX_W-1:0] s_dst;
   logic [DATA_W-1:0] s_data;
   // interrupt state
   logic              ie;
   logic [PC_W-1:0]   epc;

   logic [RIDX_W-1:0] src_a, src_b, x_dst;
   logic [DATA_W-1:0] opa, opb, x_res;
   logic              use_a, use_b, x_wen, x_redir, x_ret;
   logic [PC_W-1:0]   x_target;
   logic              raw, redirect, irq_take, flush, stall;

   pipe3_regfile #(.DATA_W(DATA_W), .RESET_REGS(RESET_REGS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(s_valid && s_wen), .wa(s_dst), .wd(s_data),
      .ra(src_a), .rb(src_b), .rda(opa), .rdb(opb)
   );

   pipe3_exec #(.DATA_W(DATA_W), .PC_W(PC_W)) u_ex (
      .insn(x_insn), .pc(x_pc), .opa(opa), .opb(opb), .epc(epc),
      .src_a(src_a), .src_b(src_b), .use_a(use_a), .use_b(use_b),
      .result(x_res), .wen(x_wen), .dst(x_dst),
      .redir(x_redir), .is_ret(x_ret), .target(x_target)
   );

   pipe3_hazard u_hz (
      .clk(clk), .rst_n(rst_n),
      .x_valid(x_valid), .use_a(use_a), .use_b(use_b),
      .src_a(src_a), .src_b(src_b),
      .s_valid(s_valid), .s_wen(s_wen), .s_dst(s_dst),
      .raw(raw)
   );

   assign redirect = s_valid && s_redir;
   assign irq_take = irq && ie && s_valid && !s_redir;
   assign flush    = redirect || irq_take;
   assign stall    = raw && !flush;

   always_comb begin
      if (redirect)      imem_addr = s_target;
      else if (irq_take) imem_addr = IRQ_VEC;
      else if (stall)    imem_addr = f_pc;
      else               imem_addr = pc_seq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_pc    <= '0;
         pc_seq  <= '0;
         f_valid <= 1'b0;
      end else begin
         f_pc    <= imem_addr;
         pc_seq  <= imem_addr + 1'b1;
         f_valid <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_valid <= 1'b0;
         x_pc    <= '0;
         x_insn  <= '0;
      end else if (flush) begin
         x_valid <= 1'b0;
      end else if (!stall) begin
         x_valid <= f_valid;
         x_pc    <= f_pc;
         x_insn  <= imem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid  <= 1'b0;
         s_wen    <= 1'b0;
         s_redir  <= 1'b0;
         s_ret    <= 1'b0;
         s_pc     <= '0;
         s_target <= '0;
         s_dst    <= '0;
         s_data   <= '0;
      end else begin
         s_valid  <= x_valid && !flush && !stall;
         s_wen    <= x_wen;
         s_redir  <= x_redir;
         s_ret    <= x_ret;
         s_pc     <= x_pc;
         s_target <= x_target;
         s_dst    <= x_dst;
         s_data   <= x_res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie  <= 1'b1;
         epc <= '0;
      end else if (irq_take) begin
         ie  <= 1'b0;
         epc <= s_pc + 1'b1;
      end else if (redirect && s_ret) begin
         ie  <= 1'b1;
      end
   end

   assign irq_ack   = irq_take;
   assign ret_valid = s_valid;
   assign ret_pc    = s_pc;
   assign ret_wen   = s_valid && s_wen;
   assign ret_rd    = s_dst;
   assign ret_data  = s_data;

   // R4
   stall_holds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(f_pc) && x_valid && !s_valid));
   // R4
   stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);
   // R7
   redirect_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (!x_valid && !s_valid && f_pc == $past(s_target)));
   // R8
   irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> (f_pc == IRQ_VEC && !ie && !x_valid));
   // R6
   zero_dst_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_wen |-> (ret_rd != '0));
endmodule

// File: tb/pipe3_core_tb.sv
`timescale 1ns/1ps
module pipe3_core_tb;
   localparam int DW  = 16;
   localparam int PW  = 8;
   localparam int VEC = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] imem_addr;
   logic [15:0]   imem_rdata = '0;
   logic          irq = 1'b0;
   logic          irq_ack, ret_valid, ret_wen;
   logic [PW-1:0] ret_pc;
   logic [2:0]    ret_rd;
   logic [DW-1:0] ret_data;

   pipe3_core #(.DATA_W(DW), .PC_W(PW), .IRQ_VEC(8'h80)) u_dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .irq(irq), .irq_ack(irq_ack), .ret_valid(ret_valid), .ret_pc(ret_pc),
      .ret_wen(ret_wen), .ret_rd(ret_rd), .ret_data(ret_data)
   );

   always #10 clk = ~clk;

   logic [15:0] prog [256];
   always @(posedge clk) imem_rdata <= prog[imem_addr];

   int vecs = 0, bad = 0;
   bit run = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      vecs++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int imm);
      logic [15:0] w;
      w[15:12] = 4'(op); w[11:9] = 3'(rd); w[8:6] = 3'(rs); w[5:0] = 6'(imm);
      return w;
   endfunction

   function automatic int sx6(input logic [5:0] v);
      return v[5] ? int'(v) - 64 : int'(v);
   endfunction

   function automatic bit reads_reg(input logic [15:0] w, input int r);
      case (int'(w[15:12]))
         2:       return (int'(w[8:6]) == r) || (int'(w[2:0]) == r);
         3, 4:    return int'(w[8:6]) == r;
         default: return 1'b0;
      endcase
   endfunction

   // behavioural reference state
   logic [DW-1:0] mreg [8];
   int    pc_m = 0, gap = 2, epc_m = 0;
   bit    ie_m = 1;
   string why = "R1";

   always @(negedge clk) begin
      if (run) begin
         if (gap > 0) begin
            chk(ret_valid == 1'b0, why, "bubble slot ret_valid", int'(ret_valid), 0);
            chk(irq_ack == 1'b0, "R8", "irq_ack in bubble slot", int'(irq_ack), 0);
            gap--;
         end else begin
            logic [15:0]   w;
            logic [DW-1:0] val;
            int op, rd, rs, rt, npc;
            bit writes, wen_e, redir, ack_e;
            string nwhy;
            w = prog[pc_m];
            op = int'(w[15:12]); rd = int'(w[11:9]); rs = int'(w[8:6]); rt = int'(w[2:0]);
            val = '0; writes = 0; redir = 0; npc = (pc_m + 1) % 256; nwhy = "R2";
            case (op)
               1: begin val = DW'(sx6(w[5:0])); writes = 1; end
               2: begin val = mreg[rs] + mreg[rt]; writes = 1; end
               3: begin val = mreg[rs] + DW'(sx6(w[5:0])); writes = 1; end
               4: if (mreg[rs] != 0) begin npc = (pc_m + sx6(w[5:0]) + 256) % 256; redir = 1; nwhy = "R7"; end
               5: begin npc = epc_m; redir = 1; nwhy = "R9"; end
               default: ;
            endcase
            wen_e = writes && (rd != 0);
            chk(ret_valid == 1'b1, why, "retire slot ret_valid", int'(ret_valid), 1);
            chk(int'(ret_pc) == pc_m, why, "retired pc", int'(ret_pc), pc_m);
            chk(ret_wen == wen_e, (rd == 0) ? "R6" : "R3", "ret_wen", int'(ret_wen), int'(wen_e));
            if (wen_e) begin
               chk(int'(ret_rd) == rd, "R3", "ret_rd", int'(ret_rd), rd);
               chk(ret_data == val, "R3", "ret_data", int'(ret_data), int'(val));
               mreg[rd] = val;
            end
            ack_e = irq && ie_m && !redir;
            chk(irq_ack == ack_e, ie_m ? "R8" : "R9", "irq_ack", int'(irq_ack), int'(ack_e));
            if (op == 5) ie_m = 1;
            if (ack_e) begin
               epc_m = (pc_m + 1) % 256; ie_m = 0; npc = VEC; redir = 1; nwhy = "R8";
            end
            pc_m = npc;
            if (redir) gap = 2;
            else if (wen_e && reads_reg(prog[npc], rd)) begin gap = 1; nwhy = "R4"; end
            else gap = 0;
            why = nwhy;
         end
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      prog[0]  = enc(1, 1, 0, 5);        // r1 = 5
      prog[1]  = enc(2, 2, 1, 1);        // R4: r2 = r1 + r1, stall
      prog[2]  = enc(3, 3, 2, -3);       // R4: r3 = r2 - 3, stall
      prog[3]  = enc(1, 4, 0, 1);
      prog[4]  = enc(3, 5, 3, 2);        // R5: distance two, no stall
      prog[5]  = enc(3, 0, 1, 7);        // R6: write to r0 dropped
      prog[6]  = enc(2, 6, 0, 0);        // R5: r0 source, no stall
      prog[7]  = enc(1, 7, 0, -1);
      prog[8]  = enc(3, 7, 7, 1);        // R3: wraps to zero
      prog[9]  = enc(4, 0, 7, 5);        // R7: not taken
      prog[10] = enc(1, 1, 0, 3);
      prog[11] = enc(3, 1, 1, -1);
      prog[12] = enc(4, 0, 1, -1);       // R7: taken backward twice
      for (int i = 13; i <= 40; i++) prog[i] = enc(1, 3 + (i % 2), 0, i);
      prog[20] = enc(15, 3, 1, 5);       // R3: undefined opcode, no effect
      prog[41] = enc(1, 7, 0, 1);
      prog[43] = enc(4, 0, 7, 0);        // self loop, always redirecting
      prog[VEC]     = enc(1, 6, 0, 21);
      prog[VEC + 1] = enc(3, 6, 6, 1);
      prog[VEC + 2] = enc(5, 0, 0, 0);   // R9: return
      prog[VEC + 3] = enc(1, 6, 0, 9);   // must never retire

      repeat (3) @(negedge clk);
      chk(ret_valid == 1'b0, "R1", "reset ret_valid", int'(ret_valid), 0);
      chk(irq_ack == 1'b0, "R1", "reset irq_ack", int'(irq_ack), 0);
      chk(imem_addr == '0, "R1", "reset fetch address", int'(imem_addr), 0);
      rst_n = 1'b1;
      @(posedge clk); #1 run = 1;

      repeat (40) @(posedge clk);
      #2 irq = 1'b1;
      do @(negedge clk); while (!irq_ack);
      repeat (4) @(posedge clk);         // R9: still high while masked
      #2 irq = 1'b0;
      repeat (70) @(posedge clk);
      #2 irq = 1'b1;                     // R8: redirecting loop refuses it
      repeat (30) @(posedge clk);
      #2 irq = 1'b0;
      repeat (5) @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      #(20 * 5000);
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule